// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps the time of day and the calendar as packed-BCD registers: a tenths-of-second digit, seconds, minutes, hours, date, month, a two-digit year and a day-of-week count. A prescaler divides the system clock down to a 10 Hz tick that drives the tenths digit. Each time the tenths digit wraps, the seconds advance and a carry ripples up through the calendar. The hour register holds either a 24-hour count or a 12-hour count with an AM/PM flag. The date wraps at the true length of the current month. Every year divisible by four is treated as a leap year.

A register access block loads the fields one at a time, through a write strobe with a 3-bit field address. Any write clears the tenths digit and freezes counting. A separate strobe marks the stop condition that ends the write transaction. Counting resumes from that point, so the next second boundary falls exactly ten tenths later. Alarm logic uses the full time vector together with a one-cycle pulse that marks each new second.

Top module: `bcd_clock`

## Requirements
- R1: After reset the tenths digit, seconds, minutes, year and day of week are 0. The hour register is 8'h00, which means 12-hour mode with the PM flag clear. Date and month are 8'h01, and the second pulse is low.
- R2: The tenths digit counts 0 through 9, advancing once every TENTH_DIV clocks. It is read-only. Any write, including a write to field address 7, clears it to 0 on the next clock and changes no other field.
- R3: Seconds and minutes count 8'h00 to 8'h59 in BCD. Seconds wrap to 00 when the tenths digit wraps from 9. A seconds wrap from 59 advances the minutes. A minutes wrap from 59 advances the hour.
- R4: When hour bit 7 is 1, the hour counts 8'h80 to 8'hA3 (BCD 00 to 23 in bits 5:0). Advancing past 23 gives 00 and advances the date.
- R5: When hour bit 7 is 0, the hour is 12-hour BCD in bits 4:0, and bit 5 is the PM flag (1 means PM). The sequence is 12, 01 … 11, 12. The PM flag toggles on the step from 11 to 12. The step from 11 PM to 12 AM advances the date.
- R6: The date wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the other months, and 29 for month 02 when the BCD year is a multiple of 4, otherwise 28.
- R7: A date wrap advances the month. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00. The day of week advances 0 through 6 and back to 0, once per date change.
- R8: A write loads wr_data into the field at wr_addr on the next clock. The field addresses are: 0 seconds (bits 6:0), 1 minutes (bits 6:0), 2 hour (bits 7 and 5:0), 3 date (bits 5:0), 4 month (bits 4:0), 5 year (bits 7:0) and 6 day of week (bits 2:0). Bits not listed are stored as 0.
- R9: After a write, the counters hold until wr_done is seen. The clock edge that samples wr_done restarts the prescaler. The tenths digit then reaches 1 exactly TENTH_DIV clocks later, and the seconds advance exactly 10*TENTH_DIV clocks later.
- R10: sec_pulse is high for exactly one clock, the cycle in which the seconds register shows its new value. In that cycle the tenths digit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field address of the write |
| wr_data | input | 8 | Write data |
| wr_done | input | 1 | Stop condition that ends a timekeeping write |
| tenths | output | 4 | Tenths-of-second digit |
| sec | output | 8 | Seconds, BCD |
| min | output | 8 | Minutes, BCD |
| hour | output | 8 | Hour register: mode bit 7, PM bit 5, BCD count |
| date | output | 8 | Date, BCD |
| month | output | 8 | Month, BCD |
| year | output | 8 | Year, BCD |
| dow | output | 3 | Day of week |
| sec_pulse | output | 1 | One-clock pulse on each new second |

## Verification
Each vector loads a complete time, releases it with wr_done and observes one full second. In the cycle before the boundary, nothing may have moved yet. In the boundary cycle, every field must show the next second. Random vectors bias seconds and minutes toward 59, the date toward the last day of the month, and mix the two hour modes, so carries stop at every level of the chain. Directed vectors cover the leap-year rule (year 24, year 00 and year 23 in February), the year and month wrap, and the 12-hour steps at 11 AM, 11 PM and 12. Together these separate a wrong month-length table, a misplaced PM toggle and a day-of-week count that steps at the wrong time. A mid-second write to the read-only field shows that the tenths digit clears and that the other fields are left alone.

// File: rtl/bcd_clock.sv
module bcd_clock #(
  parameter int TENTH_DIV = 5000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       wr_done,
  output logic [3:0] tenths,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic [7:0] date,
  output logic [7:0] month,
  output logic [7:0] year,
  output logic [2:0] dow,
  output logic       sec_pulse
);
  localparam int PW = (TENTH_DIV > 1) ? $clog2(TENTH_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TENTH_DIV - 1);

  logic [PW-1:0] pre;
  logic          held;

  function automatic logic [7:0] inc_bcd(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  logic       tick, sec_wrap, min_wrap, hr_step, day_step, mon_step, leap, pm, mode24;
  logic [7:0] last_day, nx_hour;

  assign tick     = (pre == PRE_LAST);
  assign mode24   = hour[7];
  assign pm       = hour[5];
  assign sec_wrap = (sec == 8'h59);
  assign min_wrap = (min == 8'h59);
  assign hr_step  = sec_wrap && min_wrap;
  assign day_step = hr_step && (mode24 ? (hour[5:0] == 6'h23) : (hour[4:0] == 5'h11 && pm));
  assign mon_step = day_step && (date == last_day);
  assign leap     = year[4] ? (year[3:0] == 4'h2 || year[3:0] == 4'h6)
                            : (year[3:0] == 4'h0 || year[3:0] == 4'h4 || year[3:0] == 4'h8);

  always_comb begin
    case (month)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
    if (mode24)
      nx_hour = (hour[5:0] == 6'h23) ? 8'h80 : {2'b10, inc_bcd({2'b00, hour[5:0]})[5:0]};
    else if (hour[4:0] == 5'h11)
      nx_hour = {2'b00, ~pm, 5'h12};
    else if (hour[4:0] == 5'h12)
      nx_hour = {2'b00, pm, 5'h01};
    else
      nx_hour = {2'b00, pm, inc_bcd({3'b000, hour[4:0]})[4:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0; held <= 1'b0; tenths <= 4'd0; sec_pulse <= 1'b0;
      sec <= 8'h00; min <= 8'h00; hour <= 8'h00; date <= 8'h01;
      month <= 8'h01; year <= 8'h00; dow <= 3'd0;
    end else begin
      sec_pulse <= 1'b0;
      if (wr_en) begin
        held <= 1'b1; pre <= '0; tenths <= 4'd0;
        case (wr_addr)
          3'd0: sec   <= {1'b0, wr_data[6:0]};
          3'd1: min   <= {1'b0, wr_data[6:0]};
          3'd2: hour  <= {wr_data[7], 1'b0, wr_data[5:0]};
          3'd3: date  <= {2'b00, wr_data[5:0]};
          3'd4: month <= {3'b000, wr_data[4:0]};
          3'd5: year  <= wr_data;
          3'd6: dow   <= wr_data[2:0];
          default: ;
        endcase
      end else if (wr_done) begin
        held <= 1'b0; pre <= '0;
      end else if (!held) begin
        if (!tick) pre <= pre + 1'b1;
        else begin
          pre <= '0;
          if (tenths != 4'd9) tenths <= tenths + 4'd1;
          else begin
            tenths <= 4'd0; sec_pulse <= 1'b1;
            sec <= sec_wrap ? 8'h00 : inc_bcd(sec);
            if (sec_wrap) min <= min_wrap ? 8'h00 : inc_bcd(min);
            if (hr_step) hour <= nx_hour;
            if (day_step) begin
              date <= (date == last_day) ? 8'h01 : inc_bcd(date);
              dow  <= (dow == 3'd6) ? 3'd0 : dow + 3'd1;
            end
            if (mon_step) month <= (month == 8'h12) ? 8'h01 : inc_bcd(month);
            if (mon_step && month == 8'h12) year <= (year == 8'h99) ? 8'h00 : inc_bcd(year);
          end
        end
      end
    end
  end

  AST_TENTHS_RANGE: assert property (@(posedge clk) disable iff (!rst_n) tenths <= 4'd9); // R2
  AST_WRITE_CLEARS_TENTHS: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> tenths == 4'd0); // R2
  AST_PULSE_AT_ZERO_TENTHS: assert property (@(posedge clk) disable iff (!rst_n) sec_pulse |-> tenths == 4'd0); // R10
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) sec_pulse |=> !sec_pulse); // R10
  AST_NO_PULSE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !sec_pulse); // R9
  AST_HELD_NO_SEC_CHANGE: assert property (@(posedge clk) disable iff (!rst_n) held && !wr_en |=> $stable(sec)); // R9
endmodule

// File: tb/bcd_clock_bench.sv
module bcd_clock_bench;
  localparam int DIV = 4;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_done = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [3:0] tenths;
  logic [7:0] sec, min, hour, date, month, year;
  logic [2:0] dow;
  logic sec_pulse;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  bcd_clock #(.TENTH_DIV(DIV)) u_bcd_clock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_done(wr_done), .tenths(tenths), .sec(sec), .min(min), .hour(hour), .date(date),
    .month(month), .year(year), .dow(dow), .sec_pulse(sec_pulse));

  int e_s, e_m, e_h, e_d, e_mo, e_y, e_w;
  bit e_pm, e_24;

  function automatic logic [7:0] bcd(input int x);
    return {4'(x / 10), 4'(x % 10)};
  endfunction
  function automatic int days_in(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  function automatic logic [7:0] hour_byte(input bit m24, input bit p, input int h);
    return m24 ? (8'h80 | bcd(h)) : ({2'b00, p, 5'b0} | bcd(h));
  endfunction

  task automatic model_step();
    bit day = 1'b0;
    e_s++;
    if (e_s == 60) begin
      e_s = 0; e_m++;
      if (e_m == 60) begin
        e_m = 0;
        if (e_24) begin e_h++; if (e_h == 24) begin e_h = 0; day = 1'b1; end end
        else if (e_h == 11) begin e_h = 12; e_pm = !e_pm; day = !e_pm; end
        else if (e_h == 12) e_h = 1;
        else e_h++;
      end
    end
    if (day) begin
      e_w = (e_w + 1) % 7;
      if (e_d == days_in(e_mo, e_y)) begin
        e_d = 1; e_mo++;
        if (e_mo == 13) begin e_mo = 1; e_y = (e_y + 1) % 100; end
      end else e_d++;
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string when);
    chk({when, " R3 sec"}, sec, bcd(e_s));
    chk({when, " R3 min"}, min, bcd(e_m));
    chk({when, e_24 ? " R4 hour" : " R5 hour"}, hour, hour_byte(e_24, e_pm, e_h));
    chk({when, " R6 date"}, date, bcd(e_d));
    chk({when, " R7 month"}, month, bcd(e_mo));
    chk({when, " R7 year"}, year, bcd(e_y));
    chk({when, " R7 dow"}, {5'b0, dow}, 8'(e_w));
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic stop();
    @(negedge clk); wr_done = 1'b1;
    @(posedge clk); #1 wr_done = 1'b0;
  endtask

  task automatic run_vector(input int s, input int m, input bit m24, input bit p, input int h,
                            input int d, input int mo, input int y, input int w);
    e_s = s; e_m = m; e_24 = m24; e_pm = p; e_h = h; e_d = d; e_mo = mo; e_y = y; e_w = w;
    wr(3'd0, bcd(s)); wr(3'd1, bcd(m)); wr(3'd2, hour_byte(m24, p, h));
    wr(3'd3, bcd(d)); wr(3'd4, bcd(mo)); wr(3'd5, bcd(y)); wr(3'd6, 8'(w));
    chk_all("R8 load");
    chk("R2 tenths after write", {4'b0, tenths}, 8'h00);
    stop();
    repeat (DIV) @(posedge clk);
    #1 chk("R9 first tenth", {4'b0, tenths}, 8'h01);
    repeat (9 * DIV - 1) @(posedge clk);
    #1 chk("R9 no early pulse", {7'b0, sec_pulse}, 8'h00);
    chk("R9 sec before boundary", sec, bcd(e_s));
    @(posedge clk); #1;
    model_step();
    chk("R10 pulse", {7'b0, sec_pulse}, 8'h01);
    chk("R10 tenths at pulse", {4'b0, tenths}, 8'h00);
    chk_all("step");
    @(posedge clk); #1 chk("R10 pulse one cycle", {7'b0, sec_pulse}, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd20240511);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    e_s = 0; e_m = 0; e_24 = 0; e_pm = 0; e_h = 0; e_d = 1; e_mo = 1; e_y = 0; e_w = 0;
    chk_all("R1 reset");
    chk("R1 tenths", {4'b0, tenths}, 8'h00);
    chk("R1 pulse", {7'b0, sec_pulse}, 8'h00);

    // R2: mid-second write to read-only field clears tenths only
    repeat (3 * DIV) @(posedge clk);
    #1 chk("R2 tenths counting", {4'b0, tenths}, 8'h03);
    wr(3'd7, 8'hFF);
    chk("R2 tenths cleared", {4'b0, tenths}, 8'h00);
    chk_all("R2 addr7 no effect");
    repeat (50) @(posedge clk);
    #1 chk("R9 held tenths", {4'b0, tenths}, 8'h00);
    chk("R9 held sec", sec, 8'h00);
    stop();

    run_vector(59, 59, 1'b0, 1'b0, 11, 5, 3, 10, 2);  // R5 11 AM -> 12 PM
    run_vector(59, 59, 1'b0, 1'b1, 11, 5, 3, 10, 6);  // R5 11 PM -> 12 AM, day
    run_vector(59, 59, 1'b0, 1'b1, 12, 5, 3, 10, 2);  // R5 12 -> 01
    run_vector(59, 59, 1'b1, 1'b0, 23, 28, 2, 24, 3); // R6 leap
    run_vector(59, 59, 1'b1, 1'b0, 23, 29, 2, 0, 3);  // R6 year 00 leap
    run_vector(59, 59, 1'b1, 1'b0, 23, 28, 2, 23, 3); // R6 non-leap
    run_vector(59, 59, 1'b1, 1'b0, 23, 30, 4, 23, 5); // R6 30-day
    run_vector(59, 59, 1'b1, 1'b0, 23, 31, 12, 99, 6); // R7 year wrap

    for (int i = 0; i < 40; i++) begin
      int mo, y, d, h, s, m;
      bit m24, p;
      mo = 1 + int'($urandom % 12);
      y = int'($urandom % 100);
      d = ($urandom % 2) ? days_in(mo, y) : 1 + int'($urandom % days_in(mo, y));
      m24 = 1'($urandom % 2);
      p = 1'($urandom % 2);
      h = m24 ? int'($urandom % 24) : 1 + int'($urandom % 12);
      s = ($urandom % 3 != 0) ? 59 : int'($urandom % 60);
      m = ($urandom % 3 != 0) ? 59 : int'($urandom % 60);
      run_vector(s, m, m24, p, h, d, mo, y, int'($urandom % 7));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule